// File: doc/BRIEF.md
# Parallel Multi-Pattern PRBS Generator

This block produces a maximal-length pseudo-random bit sequence sixteen bits per clock. The output feeds a downstream 16:1 serializer. Each output word holds the next sixteen consecutive serial bits. The earliest bit in serial order sits in bit 15 and the latest in bit 0. The register is advanced sixteen steps per clock by a fully parallel next-state network. There is no bit-serial shift clock. Five feedback polynomials can be chosen while the block runs, covering sequence lengths of 2^7-1, 2^10-1, 2^15-1, 2^23-1 and 2^31-1 bits.

A shaping stage after the sequence logic sets the mark density, which is the fraction of ones in the output. The raw sequence gives one half. An AND of the sequence with one older tap of itself gives one quarter. An AND with two older taps gives one eighth.

The block holds 31 bits of sequence history. Reset and every change of the pattern select load that history with all ones, so the register never reaches the all-zero lock-up state.

Top module: `prbs_par_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `data_out` becomes 0 and the 31-bit history becomes all ones. The first enabled word after reset is therefore computed from a history of 31 ones.
- R2: The serial sequence obeys b[k] = b[k-N] xor b[k-M]. Pattern codes map as follows: 0 gives (N,M)=(7,6), 1 gives (10,7), 2 gives (15,14), 3 gives (23,18) and 4 gives (31,28).
- R3: Each edge with `en` high and no reseed loads `data_out` with the next sixteen bits. Bit 15 holds the earliest bit and bit 0 the latest.
- R4: Pattern codes 5, 6 and 7 behave exactly like code 4.
- R5: With `dens_sel` = 1, each output bit is b[t] AND b[t-5].
- R6: With `dens_sel` = 2, each output bit is b[t] AND b[t-5] AND b[t-11]. `dens_sel` = 0 and `dens_sel` = 3 both pass b[t] unchanged.
- R7: An edge with `en` low and no reseed leaves both `data_out` and the history unchanged. The next enabled word continues the sequence without a gap.
- R8: At an edge where `pat_sel` differs from its value at the previous edge, the history reloads to all ones and `data_out` holds. This happens whatever the level of `en`.
- R9: With code 0 and density one half, 127 consecutive words contain exactly 1024 ones, and word 128 repeats word 1.
- R10: A change of `dens_sel` does not reseed. It takes effect on the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the sequence by one word |
| pat_sel | input | 3 | Polynomial code (0..4, 5..7 act as 4) |
| dens_sel | input | 2 | Mark density: 0 and 3 give 1/2, 1 gives 1/4, 2 gives 1/8 |
| data_out | output | 16 | Registered word, bit 15 earliest in serial order |

## Verification
Two situations are hard to reach from the ports. The first is a reseed on an edge where `en` is low: the history must reload even though nothing is produced. The second is a full-period repeat of the short pattern, which needs 128 back-to-back words. The stimulus changes `pat_sel` while `en` is low and checks that the next words restart from the all-ones seed. It also runs 128 uninterrupted words on code 0, counting ones and comparing the last word with the first. A serial bit-by-bit reference model with its own 31-bit history produces every expected word. Density and enable changes are mixed in so that the shaping taps always reach back across word boundaries.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned HIST_W  = 31;
    localparam int unsigned NUM_PAT = 5;
    localparam int unsigned TAP_A   = 5;
    localparam int unsigned TAP_B   = 11;
    localparam int unsigned PSEL_W  = 3;

    typedef enum logic [1:0] {
        DENS_HALF    = 2'd0,
        DENS_QUARTER = 2'd1,
        DENS_EIGHTH  = 2'd2,
        DENS_SPARE   = 2'd3
    } dens_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HIST_W-1:0] hist_t;

    typedef struct packed {
        word_t raw;
        word_t shaped;
    } word_pair_t;

    function automatic int unsigned pat_degree(input int unsigned idx);
        case (idx)
            0:       return 7;
            1:       return 10;
            2:       return 15;
            3:       return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int unsigned pat_tap(input int unsigned idx);
        case (idx)
            0:       return 6;
            1:       return 7;
            2:       return 14;
            3:       return 18;
            default: return 28;
        endcase
    endfunction

    function automatic logic [PSEL_W-1:0] clamp_sel(input logic [PSEL_W-1:0] sel);
        if (sel >= PSEL_W'(NUM_PAT))
            return PSEL_W'(NUM_PAT - 1);
        return sel;
    endfunction

endpackage

// File: rtl/prbs_step_unit.sv
module prbs_step_unit
    import prbs_pkg::*;
#(
    parameter int unsigned DEG = 7,
    parameter int unsigned TAP = 6
) (
    input  hist_t hist_in,
    output hist_t hist_out
);
    localparam int unsigned EXT_W = WORD_W + HIST_W;

    // Sixteen recurrence steps unrolled: ext[j] is the bit that is
    // (WORD_W-1-j) positions after the first new bit of this word.
    always_comb begin
        logic [EXT_W-1:0] ext;
        ext = {hist_in, {WORD_W{1'b0}}};
        for (int j = WORD_W - 1; j >= 0; j--) begin
            ext[j] = ext[j + DEG] ^ ext[j + TAP];
        end
        hist_out = ext[HIST_W-1:0];
    end

    initial begin
        assert (DEG > TAP && DEG <= HIST_W && TAP > 0)
            else $error("prbs_step_unit: bad polynomial parameters");
    end

endmodule

// File: rtl/prbs_density_shaper.sv
module prbs_density_shaper
    import prbs_pkg::*;
#(
    parameter int unsigned TAP_1 = TAP_A,
    parameter int unsigned TAP_2 = TAP_B
) (
    input  logic [WORD_W+TAP_2-1:0] seq_in,
    input  dens_e                   dens,
    output word_pair_t              pair
);
    word_t one_tap;
    word_t two_tap;

    generate
        for (genvar j = 0; j < WORD_W; j++) begin : g_bit
            assign one_tap[j] = seq_in[j] & seq_in[j + TAP_1];
            assign two_tap[j] = seq_in[j] & seq_in[j + TAP_1] & seq_in[j + TAP_2];
        end
    endgenerate

    always_comb begin
        pair.raw = seq_in[WORD_W-1:0];
        unique case (dens)
            DENS_QUARTER: pair.shaped = one_tap;
            DENS_EIGHTH:  pair.shaped = two_tap;
            default:      pair.shaped = seq_in[WORD_W-1:0];
        endcase
    end

    initial begin
        assert (TAP_1 < TAP_2 && WORD_W + TAP_2 <= HIST_W)
            else $error("prbs_density_shaper: taps exceed history");
    end

endmodule

// File: rtl/prbs_par_gen.sv
module prbs_par_gen
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PSEL_W-1:0] pat_sel,
    input  logic [1:0]        dens_sel,
    output logic [WORD_W-1:0] data_out
);
    localparam int unsigned SHAPE_W = WORD_W + TAP_B;

    hist_t             hist_q;
    logic [PSEL_W-1:0] sel_q;
    hist_t             nxt_hist [NUM_PAT];
    hist_t             nxt_sel;
    logic [PSEL_W-1:0] sel_idx;
    logic              reseed;
    word_pair_t        pair;

    generate
        for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
            localparam int unsigned P_DEG = pat_degree(p);
            localparam int unsigned P_TAP = pat_tap(p);
            prbs_step_unit #(
                .DEG (P_DEG),
                .TAP (P_TAP)
            ) step_i (
                .hist_in  (hist_q),
                .hist_out (nxt_hist[p])
            );
        end
    endgenerate

    assign sel_idx = clamp_sel(pat_sel);
    assign nxt_sel = nxt_hist[sel_idx];
    assign reseed  = (pat_sel != sel_q);

    prbs_density_shaper #(
        .TAP_1 (TAP_A),
        .TAP_2 (TAP_B)
    ) shaper_i (
        .seq_in (nxt_sel[SHAPE_W-1:0]),
        .dens   (dens_e'(dens_sel)),
        .pair   (pair)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q   <= '1;
            data_out <= '0;
            sel_q    <= pat_sel;
        end else begin
            sel_q <= pat_sel;
            if (reseed) begin
                hist_q <= '1;
            end else if (en) begin
                hist_q   <= nxt_sel;
                data_out <= pair.shaped;
            end
        end
    end

    // R8
    reseed_chk: assert property (@(posedge clk) disable iff (rst)
        reseed |=> (hist_q == '1) && $stable(data_out));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !reseed) |=> $stable(data_out) && $stable(hist_q));

    // R2
    no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
        hist_q != '0);

    // R5
    quarter_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !reseed && dens_sel == 2'd1) |=>
            ((data_out & ~$past(nxt_sel[WORD_W-1:0])) == '0));

    // R6
    eighth_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !reseed && dens_sel == 2'd2) |=>
            ((data_out & ~$past(pair.raw) & ~$past(data_out)) == '0 ||
             (data_out & ~$past(nxt_sel[WORD_W-1:0])) == '0));

endmodule

// File: tb/prbs_par_gen_tb_top.sv
module prbs_par_gen_tb_top;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [2:0]  pat_sel  = 3'd0;
    logic [1:0]  dens_sel = 2'd0;
    logic [15:0] data_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    item_t       sb_q[$];
    logic [15:0] cap[$];

    logic [30:0] m_hist;
    logic [2:0]  m_prev;
    logic [15:0] m_last;

    always #10 clk = ~clk;

    prbs_par_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .pat_sel  (pat_sel),
        .dens_sel (dens_sel),
        .data_out (data_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int deg_of(input logic [2:0] c);
        case (c)
            3'd0: return 7;
            3'd1: return 10;
            3'd2: return 15;
            3'd3: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int tap_of(input logic [2:0] c);
        case (c)
            3'd0: return 6;
            3'd1: return 7;
            3'd2: return 14;
            3'd3: return 18;
            default: return 28;
        endcase
    endfunction

    // Serial reference: m_hist[0] is the newest bit.
    task automatic model_word(input logic [2:0] pat, input logic [1:0] dens,
                              output logic [15:0] shaped);
        int n = deg_of(pat);
        int m = tap_of(pat);
        for (int i = 0; i < 16; i++) begin
            logic nb;
            logic sb;
            nb = m_hist[n-1] ^ m_hist[m-1];
            case (dens)
                2'd1:    sb = nb & m_hist[4];
                2'd2:    sb = nb & m_hist[4] & m_hist[10];
                default: sb = nb;
            endcase
            shaped[15-i] = sb;
            m_hist = {m_hist[29:0], nb};
        end
    endtask

    task automatic step(input logic e, input logic [2:0] pat,
                        input logic [1:0] dens, input string tag);
        item_t it;
        @(negedge clk);
        en       = e;
        pat_sel  = pat;
        dens_sel = dens;
        if (pat != m_prev) begin
            m_hist = '1;
        end else if (e) begin
            model_word(pat, dens, m_last);
        end
        m_prev = pat;
        it.exp = m_last;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare halfway between edges.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, data_out, it.exp);
                if (it.tag == "R9") cap.push_back(data_out);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset output", data_out, 16'h0000);

        @(negedge clk);
        rst    = 1'b0;
        m_hist = '1;
        m_prev = 3'd0;
        m_last = 16'h0000;

        // R1, R2, R3: first words of code 0 from the all-ones history
        for (int i = 0; i < 12; i++) step(1'b1, 3'd0, 2'd0, "R3");
        // R7: enable low holds, then continues
        for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 2'd0, "R7");
        for (int i = 0; i < 4; i++) step(1'b1, 3'd0, 2'd0, "R7");

        // R8 and R2 over the other codes
        for (int c = 1; c < 5; c++) begin
            step(1'b1, 3'(c), 2'd0, "R8");
            for (int i = 0; i < 8; i++) step(1'b1, 3'(c), 2'd0, "R2");
        end

        // R4: code 6 reseeds and then runs like code 4
        step(1'b1, 3'd6, 2'd0, "R8");
        for (int i = 0; i < 6; i++) step(1'b1, 3'd6, 2'd0, "R4");
        step(1'b1, 3'd5, 2'd0, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 3'd5, 2'd0, "R4");

        // R5, R6, R10: density changes without reseed
        for (int i = 0; i < 8; i++) step(1'b1, 3'd5, 2'd1, "R5");
        for (int i = 0; i < 8; i++) step(1'b1, 3'd5, 2'd2, "R6");
        for (int i = 0; i < 4; i++) step(1'b1, 3'd5, 2'd3, "R6");
        for (int i = 0; i < 6; i++) step(1'b1, 3'd5, 2'(i % 3), "R10");

        // R8: reseed while enable is low
        step(1'b0, 3'd2, 2'd1, "R8");
        step(1'b0, 3'd2, 2'd1, "R8");
        for (int i = 0; i < 6; i++) step(1'b1, 3'd2, 2'd1, "R8");

        // R9: full period of code 0
        step(1'b1, 3'd0, 2'd0, "R8");
        for (int i = 0; i < 128; i++) step(1'b1, 3'd0, 2'd0, "R9");

        repeat (3) @(posedge clk);
        #6;

        begin
            int ones = 0;
            for (int i = 0; i < 127; i++) ones += $countones(cap[i]);
            check("R9 ones in 127 words", 16'(ones), 16'd1024);
            check("R9 word 128 repeats word 1", cap[127], cap[0]);
        end

        finish_run();
    end

endmodule